// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Lookup with Recency Replacement

This block holds the tag and data arrays of a small four-way set-associative cache whose lines are one 32-bit word wide. A lookup presents an address. The set bits pick one set, and the stored tags of all four ways in that set are compared against the address tag at once. When one of them is valid and matches, a hit is reported in the same cycle and that way's word is steered to the output.

A fill presents an address and a word, and the block decides where they go. If the tag is already resident, that way is rewritten in place. Otherwise the block picks an empty way, or the least recently touched way when the set is full. The way it picks is reported on the fill port, and the new tag and word are stored at the next clock edge.

Each set keeps a full recency order of its four ways. Hits and fills move a way to the front of that order. Write policy, coherence and the timing of the memory below are left to the surrounding logic.

Top module: `sa4_cache_lookup`

## Requirements
- R1: The address splits into a tag in bits 31:10 and a set number in bits 9:2. Bits 1:0 play no part in a lookup or fill, and an address that differs from a resident one only in bits 1:0 hits on the same entry.
- R2: With `lk_req` high, `lk_hit` is high in the same cycle when a valid way of the addressed set holds the address tag. `lk_data` then carries that way's word.
- R3: When `lk_req` is low, or no valid way matches, `lk_hit` is low and `lk_data` is zero.
- R4: After reset every way of every set is empty, so every lookup misses.
- R5: A fill takes effect at the clock edge that ends its cycle. A lookup of the same address in the fill cycle still misses, and one in the next cycle hits with the filled word.
- R6: A fill of a tag that is not resident, into a set with empty ways, is placed in the lowest-numbered empty way. `fill_way` gives that way number (0 to 3) during the fill cycle.
- R7: A fill of a tag that is not resident, into a full set, replaces the least recently used way of that set, and `fill_way` reports it.
- R8: A requested lookup that hits, and every fill, make the touched way the most recently used of its set. A lookup that misses leaves the order unchanged.
- R9: A fill whose tag is already resident in the set overwrites that way's word in place, reports that way on `fill_way`, and leaves the other ways untouched.
- R10: When a hitting lookup and a fill address the same set in one cycle, both updates to the recency order take effect. The lookup touch is applied first and the fill touch second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request qualifier |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_data | output | 32 | Word of the matching way, zero on a miss |
| fill_req | input | 1 | Install request |
| fill_addr | input | 32 | Byte address to install |
| fill_data | input | 32 | Word to install |
| fill_way | output | 2 | Way chosen for the fill in this cycle |

## Verification
The bench goes after the replacement choices. A design that chose any empty way other than the lowest would report the wrong `fill_way`. One that ranked ways by fill order alone, and ignored hits, would evict a block that had just been read. It also checks that a missing lookup leaves the recency order alone, and that a fill of a resident tag rewrites the existing way instead of making a second copy. Its hardest case is a hit and a fill to the same set in one cycle. A design that dropped the lookup touch there would later evict the block that had just been read, and the bench sees that block go missing after two more fills.

// File: rtl/sa4_pkg.sv
package sa4_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned OFF_W  = 2;
    parameter int unsigned IDX_W  = 8;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned WAYS   = 4;

    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned SETS  = 1 << IDX_W;
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned AGE_W = WAY_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  set_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [AGE_W-1:0]  age_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef age_t [WAYS-1:0]   age_vec_t;

    typedef struct packed {
        tag_t             tag;
        set_t             set;
        logic [OFF_W-1:0] off;
    } addr_t;

    // Age 0 is the newest way, age WAYS-1 the oldest. Touching a way
    // makes it age 0 and ages every way that was newer than it by one.
    function automatic age_vec_t touch_way(age_vec_t ages, way_t w);
        age_vec_t res;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)
                res[i] = '0;
            else if (ages[i] < ages[w])
                res[i] = ages[i] + 1'b1;
            else
                res[i] = ages[i];
        end
        return res;
    endfunction

    function automatic way_t onehot_index(logic [WAYS-1:0] oh);
        way_t w;
        w = '0;
        for (int i = 0; i < WAYS; i++)
            if (oh[i])
                w = w | way_t'(i);
        return w;
    endfunction

endpackage

// File: rtl/sa4_way_cmp.sv
module sa4_way_cmp #(
    parameter int unsigned TAG_W = 22
) (
    input  logic             valid_i,
    input  logic [TAG_W-1:0] stored_i,
    input  logic [TAG_W-1:0] probe_i,
    output logic             match_o
);
    assign match_o = valid_i && (stored_i == probe_i);
endmodule

// File: rtl/sa4_onehot_mux.sv
module sa4_onehot_mux #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [WAYS-1:0]             sel_i,
    input  logic [WAYS-1:0][DATA_W-1:0] din_i,
    output logic [DATA_W-1:0]           dout_o
);
    always_comb begin
        dout_o = '0;
        for (int i = 0; i < WAYS; i++)
            dout_o = dout_o | (din_i[i] & {DATA_W{sel_i[i]}});
    end
endmodule

// File: rtl/sa4_victim_sel.sv
module sa4_victim_sel #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned AGE_W = 2,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0]            hit_i,
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] empty_way;
    logic [WAY_W-1:0] old_way;
    logic             any_empty;

    always_comb begin
        hit_way   = '0;
        empty_way = '0;
        old_way   = '0;
        any_empty = 1'b0;
        for (int i = 0; i < WAYS; i++)
            if (hit_i[i])
                hit_way = hit_way | WAY_W'(i);
        // scan downwards so the lowest empty way is the last one kept
        for (int i = WAYS - 1; i >= 0; i--)
            if (!valid_i[i]) begin
                empty_way = WAY_W'(i);
                any_empty = 1'b1;
            end
        for (int i = 0; i < WAYS; i++)
            if (age_i[i] == AGE_W'(WAYS - 1))
                old_way = WAY_W'(i);
    end

    always_comb begin
        if (|hit_i)
            way_o = hit_way;
        else if (any_empty)
            way_o = empty_way;
        else
            way_o = old_way;
    end
endmodule

// File: rtl/sa4_cache_lookup.sv
module sa4_cache_lookup
    import sa4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic [WAY_W-1:0]  fill_way
);
    addr_t lk_a;
    addr_t fl_a;
    set_t  lk_set;
    set_t  fill_set;

    assign lk_a     = lk_addr;
    assign fl_a     = fill_addr;
    assign lk_set   = lk_a.set;
    assign fill_set = fl_a.set;

    // storage: valid bits and ages are reset flops, tag/data are plain arrays
    logic [SETS-1:0][WAYS-1:0] valid_q;
    age_vec_t [SETS-1:0]       age_q;
    tag_t                      tag_mem  [SETS][WAYS];
    word_t                     data_mem [SETS][WAYS];

    logic [WAYS-1:0]   lk_match;
    logic [WAYS-1:0]   fl_match;
    logic [WAYS-1:0]   lk_sel;
    word_t [WAYS-1:0]  lk_words;
    way_t              lk_way;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        sa4_way_cmp #(.TAG_W(TAG_W)) u_lk_cmp (
            .valid_i  (valid_q[lk_set][g]),
            .stored_i (tag_mem[lk_set][g]),
            .probe_i  (lk_a.tag),
            .match_o  (lk_match[g])
        );
        sa4_way_cmp #(.TAG_W(TAG_W)) u_fl_cmp (
            .valid_i  (valid_q[fill_set][g]),
            .stored_i (tag_mem[fill_set][g]),
            .probe_i  (fl_a.tag),
            .match_o  (fl_match[g])
        );
        assign lk_words[g] = data_mem[lk_set][g];
    end

    assign lk_sel = lk_match & {WAYS{lk_req}};
    assign lk_hit = |lk_sel;
    assign lk_way = onehot_index(lk_match);

    sa4_onehot_mux #(.WAYS(WAYS), .DATA_W(DATA_W)) u_mux (
        .sel_i  (lk_sel),
        .din_i  (lk_words),
        .dout_o (lk_data)
    );

    sa4_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_victim (
        .valid_i (valid_q[fill_set]),
        .hit_i   (fl_match),
        .age_i   (age_q[fill_set]),
        .way_o   (fill_way)
    );

    always_ff @(posedge clk) begin
        if (fill_req) begin
            tag_mem[fill_set][fill_way]  <= fl_a.tag;
            data_mem[fill_set][fill_way] <= fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_req) begin
            valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= age_t'(WAYS - 1 - w);
        end else if (lk_hit && fill_req && (lk_set == fill_set)) begin
            age_q[fill_set] <= touch_way(touch_way(age_q[lk_set], lk_way), fill_way);
        end else begin
            if (lk_hit)
                age_q[lk_set] <= touch_way(age_q[lk_set], lk_way);
            if (fill_req)
                age_q[fill_set] <= touch_way(age_q[fill_set], fill_way);
        end
    end

endmodule

// File: rtl/sa4_cache_lookup_chk.sv
module sa4_cache_lookup_chk
    import sa4_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      lk_hit,
    input logic [DATA_W-1:0]         lk_data,
    input logic [WAYS-1:0]           lk_match,
    input logic [WAYS-1:0]           fl_match,
    input logic                      fill_req,
    input logic [WAY_W-1:0]          fill_way,
    input logic [IDX_W-1:0]          lk_set,
    input logic [IDX_W-1:0]          fill_set,
    input logic [SETS-1:0][WAYS-1:0] valid_q,
    input age_vec_t [SETS-1:0]       age_q
);
    logic [WAYS-1:0] ages_seen;
    logic            fill_set_full;

    always_comb begin
        ages_seen = '0;
        for (int w = 0; w < WAYS; w++)
            ages_seen[age_q[lk_set][w]] = 1'b1;
    end

    assign fill_set_full = &valid_q[fill_set];

    // R2: at most one way of a set may match a tag
    p_one_match_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R3: a miss drives a zero word
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_data == '0));

    // R8: the recency order of a set is always a permutation
    p_age_perm_r8: assert property (@(posedge clk) disable iff (rst)
        ages_seen == {WAYS{1'b1}});

    // R6: a new tag goes to an empty way while one exists
    p_empty_first_r6: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !(|fl_match) && !fill_set_full) |-> !valid_q[fill_set][fill_way]);

    // R7: a new tag into a full set replaces the oldest way
    p_oldest_out_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !(|fl_match) && fill_set_full) |-> (age_q[fill_set][fill_way] == AGE_W'(WAYS - 1)));

    // R5: the filled way is valid after the edge
    p_fill_valid_r5: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> valid_q[$past(fill_set)][$past(fill_way)]);

    // R8, R10: the filled way becomes the newest of its set
    p_fill_newest_r8: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> (age_q[$past(fill_set)][$past(fill_way)] == '0));

    // R9: a resident tag is rewritten in its own way
    p_inplace_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_req && (|fl_match)) |-> fl_match[fill_way]);

endmodule

bind sa4_cache_lookup sa4_cache_lookup_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_hit   (lk_hit),
    .lk_data  (lk_data),
    .lk_match (lk_match),
    .fl_match (fl_match),
    .fill_req (fill_req),
    .fill_way (fill_way),
    .lk_set   (lk_set),
    .fill_set (fill_set),
    .valid_q  (valid_q),
    .age_q    (age_q)
);

// File: tb/test_sa4_cache_lookup.sv
module test_sa4_cache_lookup;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_data;
    logic        fill_req = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic [1:0]  fill_way;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sa4_cache_lookup i_sa4_cache_lookup (
        .clk       (clk),
        .rst       (rst),
        .lk_req    (lk_req),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_req  (fill_req),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .fill_way  (fill_way)
    );

    function automatic logic [31:0] mk(input logic [21:0] tag, input logic [7:0] set, input logic [1:0] off);
        return {tag, set, off};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, input bit hit, input logic [31:0] d, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        #1;
        check(req, "lk_hit", {31'b0, lk_hit}, {31'b0, hit});
        check(req, "lk_data", lk_data, hit ? d : 32'h0);
        @(posedge clk); #1;
        lk_req = 1'b0;
    endtask

    task automatic peek(input logic [31:0] a, input string req);
        @(negedge clk);
        lk_req = 1'b0; lk_addr = a;
        #1;
        check(req, "lk_hit idle", {31'b0, lk_hit}, 32'h0);
        check(req, "lk_data idle", lk_data, 32'h0);
    endtask

    task automatic fill(input logic [31:0] a, input logic [31:0] d, input logic [1:0] way, input string req);
        @(negedge clk);
        fill_req = 1'b1; fill_addr = a; fill_data = d;
        #1;
        check(req, "fill_way", {30'b0, fill_way}, {30'b0, way});
        @(posedge clk); #1;
        fill_req = 1'b0;
    endtask

    task automatic both(input logic [31:0] la, input bit hit, input logic [31:0] ld,
                        input logic [31:0] fa, input logic [31:0] fd, input logic [1:0] way,
                        input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = la;
        fill_req = 1'b1; fill_addr = fa; fill_data = fd;
        #1;
        check(req, "lk_hit", {31'b0, lk_hit}, {31'b0, hit});
        check(req, "lk_data", lk_data, hit ? ld : 32'h0);
        check(req, "fill_way", {30'b0, fill_way}, {30'b0, way});
        @(posedge clk); #1;
        lk_req = 1'b0; fill_req = 1'b0;
    endtask

    // R4, R3: empty after reset
    task automatic t_reset();
        look(mk(22'h0, 8'h00, 2'b00), 1'b0, 32'h0, "R4");
        look(mk(22'h0A1, 8'h05, 2'b00), 1'b0, 32'h0, "R4");
        look(mk(22'h3FFFFF, 8'hFF, 2'b11), 1'b0, 32'h0, "R3");
    endtask

    // R5, R6, R2, R3: fill an empty set in way order
    task automatic t_basic();
        both(mk(22'h0A1, 8'h05, 2'b00), 1'b0, 32'h0,
             mk(22'h0A1, 8'h05, 2'b00), 32'h1111_0001, 2'd0, "R5");
        fill(mk(22'h0B2, 8'h05, 2'b00), 32'h2222_0002, 2'd1, "R6");
        fill(mk(22'h0C3, 8'h05, 2'b00), 32'h3333_0003, 2'd2, "R6");
        fill(mk(22'h0D4, 8'h05, 2'b00), 32'h4444_0004, 2'd3, "R6");
        look(mk(22'h0A1, 8'h05, 2'b00), 1'b1, 32'h1111_0001, "R5");
        look(mk(22'h0B2, 8'h05, 2'b00), 1'b1, 32'h2222_0002, "R2");
        look(mk(22'h0C3, 8'h05, 2'b00), 1'b1, 32'h3333_0003, "R2");
        look(mk(22'h0D4, 8'h05, 2'b00), 1'b1, 32'h4444_0004, "R2");
        peek(mk(22'h0A1, 8'h05, 2'b00), "R3");
    endtask

    // R1: offset bits ignored, set and tag bits decoded
    task automatic t_offset();
        look(mk(22'h0A1, 8'h05, 2'b11), 1'b1, 32'h1111_0001, "R1");
        look(mk(22'h0A1, 8'h06, 2'b00), 1'b0, 32'h0, "R1");
        look(mk(22'h0A0, 8'h05, 2'b00), 1'b0, 32'h0, "R1");
    endtask

    // R9: resident tag rewritten in place
    task automatic t_refill();
        fill(mk(22'h0B2, 8'h05, 2'b10), 32'h2222_F00D, 2'd1, "R9");
        look(mk(22'h0B2, 8'h05, 2'b00), 1'b1, 32'h2222_F00D, "R9");
        look(mk(22'h0A1, 8'h05, 2'b00), 1'b1, 32'h1111_0001, "R9");
        look(mk(22'h0C3, 8'h05, 2'b00), 1'b1, 32'h3333_0003, "R9");
        look(mk(22'h0D4, 8'h05, 2'b00), 1'b1, 32'h4444_0004, "R9");
    endtask

    // R7, R8: oldest way replaced, hits refresh, misses do not
    task automatic t_lru();
        fill(mk(22'h100, 8'h09, 2'b00), 32'hA000_0000, 2'd0, "R6");
        fill(mk(22'h101, 8'h09, 2'b00), 32'hA000_0001, 2'd1, "R6");
        fill(mk(22'h102, 8'h09, 2'b00), 32'hA000_0002, 2'd2, "R6");
        fill(mk(22'h103, 8'h09, 2'b00), 32'hA000_0003, 2'd3, "R6");
        look(mk(22'h100, 8'h09, 2'b00), 1'b1, 32'hA000_0000, "R8");
        look(mk(22'h1F0, 8'h09, 2'b00), 1'b0, 32'h0, "R8");
        fill(mk(22'h1F0, 8'h09, 2'b00), 32'hB000_0000, 2'd1, "R7");
        fill(mk(22'h1F1, 8'h09, 2'b00), 32'hB000_0001, 2'd2, "R7");
        look(mk(22'h103, 8'h09, 2'b00), 1'b1, 32'hA000_0003, "R8");
        fill(mk(22'h1F2, 8'h09, 2'b00), 32'hB000_0002, 2'd0, "R7");
        look(mk(22'h100, 8'h09, 2'b00), 1'b0, 32'h0, "R7");
        look(mk(22'h1F2, 8'h09, 2'b00), 1'b1, 32'hB000_0002, "R7");
    endtask

    // R10: hit and fill to one set in the same cycle
    task automatic t_same_set();
        fill(mk(22'h200, 8'h0C, 2'b00), 32'hC000_0000, 2'd0, "R10");
        fill(mk(22'h201, 8'h0C, 2'b00), 32'hC000_0001, 2'd1, "R10");
        fill(mk(22'h202, 8'h0C, 2'b00), 32'hC000_0002, 2'd2, "R10");
        fill(mk(22'h203, 8'h0C, 2'b00), 32'hC000_0003, 2'd3, "R10");
        both(mk(22'h202, 8'h0C, 2'b00), 1'b1, 32'hC000_0002,
             mk(22'h204, 8'h0C, 2'b00), 32'hC000_0004, 2'd0, "R10");
        fill(mk(22'h205, 8'h0C, 2'b00), 32'hC000_0005, 2'd1, "R10");
        fill(mk(22'h206, 8'h0C, 2'b00), 32'hC000_0006, 2'd3, "R10");
        look(mk(22'h202, 8'h0C, 2'b00), 1'b1, 32'hC000_0002, "R10");
        look(mk(22'h201, 8'h0C, 2'b00), 1'b0, 32'h0, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_offset();
        t_refill();
        t_lru();
        t_same_set();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule